// File: doc/BRIEF.md
# Variable-Length Instruction Fetch and Decode

This block sits between a prefetch buffer and an execution core of a 16-bit accumulator processor. Each clock it can accept a fetch group of two 16-bit halfwords. It works out how long each instruction is: one halfword, or an opcode halfword followed by a 16-bit argument. It then assembles complete instructions and expands each one into a wide decoded record, which it hands downstream.

The length comes from the low seven bits of the opcode halfword (the family field). The two predicated-add operation codes are the exception: they fix the length whatever the family bits hold. A fetch group can end partway through the stream of instructions. When that happens, the leftover halfword is parked in a one-entry carry buffer and becomes the first halfword of the next instruction.

Both sides use valid/ready handshakes. A flush input discards the carried halfword and any pending decoded instruction.

Top module: `hx_fetch_decode`

## Requirements
- R1: The opcode halfword splits into fields by bit position. Bits 15:11 are the operation (`out_op`), bits 10:8 are the accumulator select (`out_acc`), and bit 7 is the save-flags bit (`out_save`).
- R2: `out_kind` encodes the instruction class: 0 register, 1 immediate, 2 indexed, 3 indirect indexed, 4 predicated add register, 5 predicated add immediate, 7 illegal. The class is chosen in this order. Operation 11101 gives 4 and operation 11111 gives 5, whatever the family bits hold. Otherwise the class comes from the family field (bits 6:0): exactly 0010000 gives 1; 0000rrr gives 0; w10jj00 gives 2; w11jjyy gives 3.
- R3: Classes 1, 2, 3 and 5 take two halfwords, and `out_arg` is the second halfword. All other classes take one halfword, and `out_arg` is 0.
- R4: For classes 2 and 3, `out_width` is family bit 6 (0 word, 1 byte) and `out_jsel` is family bits 3:2. For class 3 only, `out_ysel` is family bits 1:0. For every other class these outputs are 0.
- R5: For classes 4 and 5, `out_cond` is family bits 6:4, `out_pol` is family bit 3, and `out_rsel` is family bits 2:0. For class 0, `out_rsel` is family bits 2:0. In every other case `out_cond`, `out_pol` and `out_rsel` are 0.
- R6: A family field that matches no pattern of R2 gives class 7 with `out_illegal` set. Such an instruction is one halfword long, and all its select fields and `out_arg` are 0. `out_illegal` is 0 for every other class.
- R7: Decoded instructions leave in exact stream order (`in_hw0` comes before `in_hw1`), with none lost or duplicated. This holds when an instruction straddles two fetch groups.
- R8: While `out_valid` is high and `out_ready` is low, the record stays stable and `in_ready` is low.
- R9: When the carried halfword is itself a one-halfword instruction, `in_ready` is low for that cycle.
- R10: While `flush` is high, `in_ready` is low. In the next cycle `out_valid` is 0 and the carried halfword is gone.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.
- R12: An instruction's record appears on the outputs in the cycle after the clock edge that accepts its final halfword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard carried halfword and pending record |
| in_valid | input | 1 | Fetch group present |
| in_ready | output | 1 | Fetch group accepted at this edge |
| in_hw0 | input | 16 | Earlier halfword of the group |
| in_hw1 | input | 16 | Later halfword of the group |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer takes the record |
| out_op | output | 5 | Operation |
| out_acc | output | 3 | Accumulator select |
| out_save | output | 1 | Save-flags bit |
| out_kind | output | 3 | Instruction class |
| out_width | output | 1 | Memory width, 1 = byte |
| out_rsel | output | 3 | Source register select |
| out_jsel | output | 2 | Index register select |
| out_ysel | output | 2 | Post-index register select |
| out_cond | output | 3 | Predicate flag index |
| out_pol | output | 1 | Predicate polarity |
| out_arg | output | 16 | Argument halfword |
| out_illegal | output | 1 | Unknown family |

## Verification
`in_ready` is combinational, so the bench reads it 1 ns after driving the inputs at the falling edge, in the same cycle. A decoded record is due one cycle after the edge that accepted its last halfword. The bench checks this at the next falling edge in the directed latency test.

In the random phase, a record is compared against the bench's own decode of the stream only in a cycle where `out_valid` and `out_ready` are both high. A stalled record is compared one cycle later against its own earlier snapshot. The flush result is checked at the falling edge after the flushing edge.

// File: rtl/hx_fd_pkg.sv
package hx_fd_pkg;

    localparam int HW_W  = 16;
    localparam int OP_W  = 5;
    localparam int ACC_W = 3;
    localparam int FAM_W = 7;
    localparam int SEL_W = 3;
    localparam int IDX_W = 2;

    localparam logic [OP_W-1:0]  OP_PADD_REG = 5'b11101;
    localparam logic [OP_W-1:0]  OP_PADD_IMM = 5'b11111;
    localparam logic [FAM_W-1:0] FAM_IMM     = 7'b0010000;

    typedef enum logic [2:0] {
        K_REG  = 3'd0,
        K_IMM  = 3'd1,
        K_IDX  = 3'd2,
        K_IND  = 3'd3,
        K_PREG = 3'd4,
        K_PIMM = 3'd5,
        K_ILL  = 3'd7
    } kind_e;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [ACC_W-1:0] acc;
        logic             save;
        kind_e            kind;
        logic             width;
        logic [SEL_W-1:0] rsel;
        logic [IDX_W-1:0] jsel;
        logic [IDX_W-1:0] ysel;
        logic [SEL_W-1:0] cond;
        logic             pol;
        logic [HW_W-1:0]  arg;
        logic             illegal;
    } dec_rec_t;

    typedef struct packed {
        logic            carry_v;
        logic [HW_W-1:0] carry_hw;
        logic            out_v;
        dec_rec_t        rec;
    } fd_state_t;

endpackage

// File: rtl/hx_fd_classify.sv
module hx_fd_classify
    import hx_fd_pkg::*;
(
    input  logic [HW_W-1:0] hw,
    output kind_e           kind,
    output logic            two_hw
);
    logic [OP_W-1:0]  op;
    logic [FAM_W-1:0] fam;

    always_comb begin
        op  = hw[HW_W-1 -: OP_W];
        fam = hw[FAM_W-1:0];
        if (op == OP_PADD_REG) begin
            kind = K_PREG;
        end else if (op == OP_PADD_IMM) begin
            kind = K_PIMM;
        end else if (fam == FAM_IMM) begin
            kind = K_IMM;
        end else if (fam[6:3] == 4'b0000) begin
            kind = K_REG;
        end else if (fam[5:4] == 2'b10 && fam[1:0] == 2'b00) begin
            kind = K_IDX;
        end else if (fam[5:4] == 2'b11) begin
            kind = K_IND;
        end else begin
            kind = K_ILL;
        end
        two_hw = (kind == K_IMM) || (kind == K_IDX) ||
                 (kind == K_IND) || (kind == K_PIMM);
    end
endmodule

// File: rtl/hx_fd_expand.sv
module hx_fd_expand
    import hx_fd_pkg::*;
(
    input  logic [HW_W-1:0] first_hw,
    input  logic [HW_W-1:0] second_hw,
    input  kind_e           kind,
    output dec_rec_t        rec
);
    logic [FAM_W-1:0] fam;

    always_comb begin
        fam         = first_hw[FAM_W-1:0];
        rec         = '0;
        rec.op      = first_hw[15:11];
        rec.acc     = first_hw[10:8];
        rec.save    = first_hw[7];
        rec.kind    = kind;
        case (kind)
            K_REG: begin
                rec.rsel = fam[2:0];
            end
            K_IMM: begin
                rec.arg = second_hw;
            end
            K_IDX: begin
                rec.width = fam[6];
                rec.jsel  = fam[3:2];
                rec.arg   = second_hw;
            end
            K_IND: begin
                rec.width = fam[6];
                rec.jsel  = fam[3:2];
                rec.ysel  = fam[1:0];
                rec.arg   = second_hw;
            end
            K_PREG, K_PIMM: begin
                rec.cond = fam[6:4];
                rec.pol  = fam[3];
                rec.rsel = fam[2:0];
                if (kind == K_PIMM) rec.arg = second_hw;
            end
            default: begin
                rec.illegal = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/hx_fetch_decode.sv
module hx_fetch_decode
    import hx_fd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [15:0]      in_hw0,
    input  logic [15:0]      in_hw1,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [4:0]       out_op,
    output logic [2:0]       out_acc,
    output logic             out_save,
    output logic [2:0]       out_kind,
    output logic             out_width,
    output logic [2:0]       out_rsel,
    output logic [1:0]       out_jsel,
    output logic [1:0]       out_ysel,
    output logic [2:0]       out_cond,
    output logic             out_pol,
    output logic [15:0]      out_arg,
    output logic             out_illegal
);
    fd_state_t st_d, st_q;

    logic [HW_W-1:0] first_hw;
    logic [HW_W-1:0] second_hw;
    kind_e           first_kind;
    logic            first_two;
    dec_rec_t        new_rec;
    logic            slot_free;
    logic            have_first;
    logic            fire;
    logic            take_in;

    // Head of the stream is the carried halfword when one is parked
    assign first_hw  = st_q.carry_v ? st_q.carry_hw : in_hw0;
    assign second_hw = st_q.carry_v ? in_hw0        : in_hw1;

    hx_fd_classify u_classify (
        .hw     (first_hw),
        .kind   (first_kind),
        .two_hw (first_two)
    );

    hx_fd_expand u_expand (
        .first_hw  (first_hw),
        .second_hw (second_hw),
        .kind      (first_kind),
        .rec       (new_rec)
    );

    always_comb begin
        slot_free  = !st_q.out_v || out_ready;
        have_first = st_q.carry_v || in_valid;
        // A parked one-halfword instruction would leave two spare halfwords
        in_ready   = !flush && slot_free && !(st_q.carry_v && !first_two);
        take_in    = in_valid && in_ready;
        fire       = !flush && slot_free && have_first &&
                     (st_q.carry_v ? (!first_two || in_valid) : 1'b1);

        st_d = st_q;
        if (fire) begin
            st_d.out_v   = 1'b1;
            st_d.rec     = new_rec;
            st_d.carry_v = take_in && (st_q.carry_v == first_two);
            if (take_in && (st_q.carry_v == first_two)) begin
                st_d.carry_hw = in_hw1;
            end
        end else if (out_ready) begin
            st_d.out_v = 1'b0;
        end

        if (flush) begin
            st_d.out_v   = 1'b0;
            st_d.carry_v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.out_v;
    assign out_op      = st_q.rec.op;
    assign out_acc     = st_q.rec.acc;
    assign out_save    = st_q.rec.save;
    assign out_kind    = st_q.rec.kind;
    assign out_width   = st_q.rec.width;
    assign out_rsel    = st_q.rec.rsel;
    assign out_jsel    = st_q.rec.jsel;
    assign out_ysel    = st_q.rec.ysel;
    assign out_cond    = st_q.rec.cond;
    assign out_pol     = st_q.rec.pol;
    assign out_arg     = st_q.rec.arg;
    assign out_illegal = st_q.rec.illegal;

endmodule

// File: rtl/hx_fd_checker.sv
module hx_fd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        flush,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [4:0]  out_op,
    input logic [2:0]  out_acc,
    input logic [2:0]  out_kind,
    input logic [15:0] out_arg,
    input logic        out_illegal
);
    // R8: a stalled record keeps its contents
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=>
            (out_valid && $stable(out_op) && $stable(out_acc) &&
             $stable(out_kind) && $stable(out_arg)));

    // R8: no fetch group is taken while the output is stalled
    assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R10: flush empties the output
    assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);

    // R10: nothing is accepted during flush
    assert_flush_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !in_ready);

    // R6: illegal records carry class 7 and no argument
    assert_illegal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (out_kind == 3'd7 && out_arg == 16'h0));

    // R3: register class is one halfword and has no argument
    assert_reg_arg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 3'd0) |-> (out_arg == 16'h0));

endmodule

bind hx_fetch_decode hx_fd_checker chk_i (.*);

// File: tb/hx_fetch_decode_tb_top.sv
`timescale 1ns/1ps
module hx_fetch_decode_tb_top;

    typedef struct packed {
        logic [4:0]  op;
        logic [2:0]  acc;
        logic        save;
        logic [2:0]  kind;
        logic        width;
        logic [2:0]  rsel;
        logic [1:0]  jsel;
        logic [1:0]  ysel;
        logic [2:0]  cond;
        logic        pol;
        logic [15:0] arg;
        logic        illegal;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_hw0 = '0;
    logic [15:0] in_hw1 = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [4:0]  out_op;
    logic [2:0]  out_acc;
    logic        out_save;
    logic [2:0]  out_kind;
    logic        out_width;
    logic [2:0]  out_rsel;
    logic [1:0]  out_jsel;
    logic [1:0]  out_ysel;
    logic [2:0]  out_cond;
    logic        out_pol;
    logic [15:0] out_arg;
    logic        out_illegal;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    logic [15:0] q  [0:2047];
    exp_t        ex [0:2047];
    int          nq;
    int          nexp;

    always #2.5 clk = ~clk;

    hx_fetch_decode dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] b_kind(input logic [15:0] hw);
        logic [6:0] f;
        f = hw[6:0];
        if (hw[15:11] == 5'b11101) return 3'd4;
        if (hw[15:11] == 5'b11111) return 3'd5;
        if (f == 7'b0010000) return 3'd1;
        if (f[6:3] == 4'b0000) return 3'd0;
        if (f[5:4] == 2'b10 && f[1:0] == 2'b00) return 3'd2;
        if (f[5:4] == 2'b11) return 3'd3;
        return 3'd7;
    endfunction

    function automatic bit b_long(input logic [2:0] k);
        return (k == 3'd1 || k == 3'd2 || k == 3'd3 || k == 3'd5);
    endfunction

    function automatic exp_t b_decode(input logic [15:0] hw, input logic [15:0] nx);
        exp_t e;
        logic [2:0] k;
        k = b_kind(hw);
        e = '0;
        e.op = hw[15:11]; e.acc = hw[10:8]; e.save = hw[7]; e.kind = k;
        if (b_long(k)) e.arg = nx;
        if (k == 3'd2 || k == 3'd3) begin e.width = hw[6]; e.jsel = hw[3:2]; end
        if (k == 3'd3) e.ysel = hw[1:0];
        if (k == 3'd4 || k == 3'd5) begin e.cond = hw[6:4]; e.pol = hw[3]; e.rsel = hw[2:0]; end
        if (k == 3'd0) e.rsel = hw[2:0];
        if (k == 3'd7) e.illegal = 1'b1;
        return e;
    endfunction

    function automatic exp_t cur_out();
        exp_t e;
        e.op = out_op; e.acc = out_acc; e.save = out_save; e.kind = out_kind;
        e.width = out_width; e.rsel = out_rsel; e.jsel = out_jsel; e.ysel = out_ysel;
        e.cond = out_cond; e.pol = out_pol; e.arg = out_arg; e.illegal = out_illegal;
        return e;
    endfunction

    function automatic logic [4:0] plain_op();
        logic [4:0] o;
        o = 5'($urandom);
        if (o == 5'b11101 || o == 5'b11111) o = 5'b00001;
        return o;
    endfunction

    task automatic chk_rec(input exp_t a, input exp_t e);
        chk("R1 op/acc/save", {23'd0, a.op, a.acc, a.save}, {23'd0, e.op, e.acc, e.save});
        chk("R2 kind", {29'd0, a.kind}, {29'd0, e.kind});
        chk("R3 arg", {16'd0, a.arg}, {16'd0, e.arg});
        chk("R4 width/jsel/ysel", {27'd0, a.width, a.jsel, a.ysel}, {27'd0, e.width, e.jsel, e.ysel});
        chk("R5 cond/pol/rsel", {25'd0, a.cond, a.pol, a.rsel}, {25'd0, e.cond, e.pol, e.rsel});
        chk("R6 illegal", {31'd0, a.illegal}, {31'd0, e.illegal});
    endtask

    // Build a random stream and its expected decode
    task automatic build_stream();
        int i;
        nq = 0;
        for (int n = 0; n < 700; n++) begin
            logic [15:0] hw;
            logic [6:0]  f;
            int sel;
            sel = int'($urandom % 8);
            case (sel)
                0: hw = {plain_op(), 3'($urandom), 1'($urandom), 4'b0000, 3'($urandom)};
                1: hw = {plain_op(), 3'($urandom), 1'($urandom), 7'b0010000};
                2: hw = {plain_op(), 3'($urandom), 1'($urandom), 1'($urandom), 2'b10, 2'($urandom), 2'b00};
                3: hw = {plain_op(), 3'($urandom), 1'($urandom), 1'($urandom), 2'b11, 2'($urandom), 2'($urandom)};
                4: hw = {5'b11101, 3'($urandom), 1'($urandom), 7'($urandom)};
                5: hw = {5'b11111, 3'($urandom), 1'($urandom), 7'($urandom)};
                6: begin
                    f = 7'($urandom);
                    while (b_kind({5'b00001, 4'd0, f}) != 3'd7) f = 7'($urandom);
                    hw = {plain_op(), 3'($urandom), 1'($urandom), f};
                end
                default: hw = 16'($urandom);
            endcase
            q[nq] = hw; nq++;
            if (b_long(b_kind(hw))) begin q[nq] = 16'($urandom); nq++; end
        end
        if (nq % 2 == 1) begin q[nq] = 16'h0000; nq++; end
        nexp = 0;
        i = 0;
        while (i < nq) begin
            ex[nexp] = b_decode(q[i], (i + 1 < nq) ? q[i+1] : 16'h0);
            nexp++;
            i += b_long(b_kind(q[i])) ? 2 : 1;
        end
    endtask

    initial begin
        int unsigned seed_dummy;
        int   p, k, cyc;
        bit   prev_stall;
        exp_t snap;
        exp_t ea;
        seed_dummy = $urandom(32'h5EED_1234);

        // Reset state, R11
        repeat (3) @(negedge clk);
        chk("R11 out_valid in reset", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R11 out_valid after reset", {31'd0, out_valid}, 32'd0);
        chk("R11 in_ready after reset", {31'd0, in_ready}, 32'd1);

        // R12 latency and R9 parked one-halfword instruction
        out_ready = 1'b1;
        in_hw0 = 16'b00101_010_1_0000_011;
        in_hw1 = 16'b01000_110_0_0000_101;
        in_valid = 1'b1;
        #1;
        chk("R12 group accepted", {31'd0, in_ready}, 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk("R12 record due next cycle", {31'd0, out_valid}, 32'd1);
        chk_rec(cur_out(), b_decode(16'b00101_010_1_0000_011, 16'h0));
        chk("R9 in_ready low with parked short op", {31'd0, in_ready}, 32'd0);
        @(negedge clk); #1;
        chk("R7 second halfword follows", {31'd0, out_valid}, 32'd1);
        chk_rec(cur_out(), b_decode(16'b01000_110_0_0000_101, 16'h0));
        @(negedge clk); #1;
        chk("R7 no extra record", {31'd0, out_valid}, 32'd0);

        // R10 flush drops the pending record and the carried halfword
        out_ready = 1'b0;
        in_hw0 = 16'b00011_001_0_0000_001;
        in_hw1 = 16'b00111_111_1_0000_111;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        flush = 1'b1;
        #1;
        chk("R10 in_ready low in flush", {31'd0, in_ready}, 32'd0);
        @(negedge clk);
        flush = 1'b0;
        #1;
        chk("R10 out_valid cleared", {31'd0, out_valid}, 32'd0);
        out_ready = 1'b1;
        in_hw0 = 16'b10010_100_1_0010000;
        in_hw1 = 16'hBEEF;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk("R10 carried halfword discarded", {31'd0, out_valid}, 32'd1);
        chk_rec(cur_out(), b_decode(16'b10010_100_1_0010000, 16'hBEEF));
        @(negedge clk); #1;
        chk("R10 nothing left after flush", {31'd0, out_valid}, 32'd0);

        // Random stream with random stalls on both sides
        build_stream();
        p = 0; k = 0; cyc = 0; prev_stall = 0; snap = '0;
        while (k < nexp && cyc < 100000) begin
            @(negedge clk);
            cyc++;
            if (prev_stall) begin
                chk("R8 stalled record held", {31'd0, out_valid}, 32'd1);
                ea = cur_out();
                chk("R8 stalled record stable", {31'd0, (ea == snap)}, 32'd1);
            end
            out_ready = ($urandom % 4) != 0;
            in_valid  = (p < nq) && (($urandom % 5) != 0);
            in_hw0    = (p < nq) ? q[p] : 16'h0;
            in_hw1    = (p + 1 < nq) ? q[p+1] : 16'h0;
            #1;
            if (out_valid && out_ready) begin
                chk_rec(cur_out(), ex[k]);
                chk("R7 stream order", {31'd0, (cur_out() == ex[k])}, 32'd1);
                k++;
            end
            if (out_valid && !out_ready)
                chk("R8 in_ready low while stalled", {31'd0, in_ready}, 32'd0);
            prev_stall = out_valid && !out_ready;
            snap = cur_out();
            if (in_valid && in_ready) p += 2;
        end
        chk("R7 all records delivered", k, nexp);
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R7 no surplus record", {31'd0, out_valid}, 32'd0);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule